// File: doc/BRIEF.md
# Second-Level Cache Allocation Policy Unit

This unit decides, for every transaction that the first-level caches send toward a second-level cache controller, what the controller and the bus interface should do with it. It takes the transaction's origin (data side or instruction side), its kind, the tag lookup result and the line's coherence bit, together with six mode inputs. It returns five decision flags. They say whether a missing line is reloaded into the second-level cache, whether the transaction goes out on the system bus, whether the written line is left modified, whether a hit line is invalidated, and whether an address-only broadcast is issued. Tag storage, data arrays and the bus protocol belong to the surrounding controller.

The mode inputs are registered every cycle. A transaction is always judged against the settings that were present in the cycle before its acceptance, so a change of mode never affects a transaction that is handed over in the same cycle. Transactions enter and decisions leave through valid/ready handshakes. The unit holds one decision at a time, and that decision appears in the cycle after acceptance.

Top module: `cache_alloc_policy`

## Requirements
- R1: While reset is low, out_valid is low, and in_ready is high in the first cycle after reset is released.
- R2: When the enable mode applying to a transaction is off, the decision is bus=1, alloc=0, dirty=0, inval=0, with bcast=1 only for kind 6 (zero block).
- R3: Each transaction uses the mode inputs registered at the clock edge before its acceptance. A mode change presented in the same cycle as a transaction takes effect from the next transaction.
- R4: A load (kind 0) that hits produces no bus access and no reload. A load miss goes to the bus and reloads when its origin is permitted.
- R5: With write-through off, a store (kind 1 or 2) or data castout (kind 3) that hits is kept locally and marked dirty. A store miss from a permitted origin reloads and is marked dirty. A non-permitted store miss goes to the bus only.
- R6: Data-only mode permits reload only for origin 0 (data cache). Instruction-only mode permits reload only for origin 1 (instruction cache). A hit is served the same way in both modes.
- R7: With data-only and instruction-only both set, no transaction reloads (cache locked).
- R8: With write-through on, every store or castout that writes the cache also goes to the bus, and no decision ever sets dirty.
- R9: A castout miss with flush-assist off reloads only if its coherence bit is 1. With flush-assist on, it reloads regardless of that bit (origin permission still applies). A castout miss that does not reload goes to the bus.
- R10: Flush pushes (kind 4) and store pushes (kind 5) normally go to the bus, with inval=1 on a hit. In test mode they stay off the bus, reload on a miss regardless of origin restrictions, and are never invalidated or marked dirty.
- R11: In test mode, zero-block operations (kind 6) are not broadcast, and single-beat store misses (kind 2) are neither sent to the bus nor reloaded. Outside test mode, kind 6 gets bcast=1 and bus=0. Kind 7 always gets bus=1 only.
- R12: A decision appears on out_valid exactly one cycle after its acceptance. It stays valid and unchanged while out_ready is low. in_ready is high whenever the output register is empty or is being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_enable | input | 1 | Turns second-level operation on |
| cfg_data_only | input | 1 | Reload permitted for data-side origin only |
| cfg_instr_only | input | 1 | Reload permitted for instruction-side origin only |
| cfg_write_thru | input | 1 | Write-through instead of write-back |
| cfg_test_mode | input | 1 | Local-only pushes, no zero broadcast, dropped single-beat misses |
| cfg_flush_assist | input | 1 | Castout misses reload regardless of coherence bit |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Transaction can be accepted |
| in_src | input | 1 | Origin: 0 data cache, 1 instruction cache |
| in_kind | input | 3 | 0 load, 1 store, 2 single-beat store, 3 castout, 4 flush push, 5 store push, 6 zero block, 7 other |
| in_hit | input | 1 | Tag lookup hit |
| in_coh | input | 1 | Coherence bit of a castout line |
| in_id | input | ID_W | Tag returned with the decision |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Consumer takes the decision |
| out_id | output | ID_W | Tag of the decided transaction |
| out_alloc | output | 1 | Reload/allocate the line |
| out_bus | output | 1 | Forward to the system bus |
| out_dirty | output | 1 | Leave the line modified |
| out_inval | output | 1 | Invalidate the hit line |
| out_bcast | output | 1 | Issue an address-only broadcast |

## Verification
The bench aims at the settings-latency edge. It switches the enable and the lock modes in the very cycle a transaction is offered, where a design that used the live inputs would reload or skip the bus one transaction early. It covers both lock halves and their combination, where a wrong priority lets the blocked origin reload, and castout misses across all four coherence-bit and flush-assist pairings, where a swapped condition drops or adds a reload. With the consumer stalled at random, a design that overwrote or dropped a held decision shows up as a mismatched tag or flag against the reference queue.

// File: rtl/cap_pkg.sv
// Shared encodings for the cache allocation policy unit.
// Assumes: kind codes are fixed by the producer of transactions.
package cap_pkg;

    typedef enum logic [2:0] {
        K_LOAD       = 3'd0,
        K_STORE      = 3'd1,
        K_STORE_SB   = 3'd2,
        K_CASTOUT    = 3'd3,
        K_FLUSH_PUSH = 3'd4,
        K_STORE_PUSH = 3'd5,
        K_ZERO       = 3'd6,
        K_OTHER      = 3'd7
    } kind_e;

    // Decision flags handed to the cache controller.
    typedef struct packed {
        logic alloc;
        logic bus;
        logic dirty;
        logic inval;
        logic bcast;
    } dec_t;

    localparam int DEC_W = $bits(dec_t);

endpackage

// File: rtl/cap_mode_reg.sv
// Registers the mode inputs every cycle so that a transaction sees the
// settings of the cycle before its acceptance; derives origin permissions.
// Assumes: mode inputs are synchronous to clk.
module cap_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_enable,
    input  logic cfg_data_only,
    input  logic cfg_instr_only,
    input  logic cfg_write_thru,
    input  logic cfg_test_mode,
    input  logic cfg_flush_assist,
    output logic en_q,
    output logic wt_q,
    output logic test_q,
    output logic fa_q,
    output logic allow_d,
    output logic allow_i
);
    logic do_q;
    logic io_q;

    // Capture all mode inputs; reset clears every mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            do_q   <= 1'b0;
            io_q   <= 1'b0;
            wt_q   <= 1'b0;
            test_q <= 1'b0;
            fa_q   <= 1'b0;
        end else begin
            en_q   <= cfg_enable;
            do_q   <= cfg_data_only;
            io_q   <= cfg_instr_only;
            wt_q   <= cfg_write_thru;
            test_q <= cfg_test_mode;
            fa_q   <= cfg_flush_assist;
        end
    end

    // Origin permission: each restriction blocks the other side; both lock all.
    always_comb begin
        allow_d = !io_q;
        allow_i = !do_q;
    end

endmodule

// File: rtl/cap_rules.sv
// Combinational policy: maps one transaction and the registered modes to
// the decision flags.
// Assumes: hit and coherence bit are valid alongside the kind.
module cap_rules
    import cap_pkg::*;
(
    input  logic  en,
    input  logic  wt,
    input  logic  test,
    input  logic  fa,
    input  logic  allow_d,
    input  logic  allow_i,
    input  logic  src,
    input  kind_e kind,
    input  logic  hit,
    input  logic  coh,
    output dec_t  dec
);
    logic permit;
    logic co_take;

    // Origin permission for this transaction and castout reload condition.
    always_comb begin
        permit  = src ? allow_i : allow_d;
        co_take = permit && (coh || fa);
    end

    // Decision table by kind.
    always_comb begin
        dec = '0;
        if (!en) begin
            dec.bus   = 1'b1;
            dec.bcast = (kind == K_ZERO);
        end else begin
            unique case (kind)
                K_LOAD: begin
                    dec.bus   = !hit;
                    dec.alloc = !hit && permit;
                end
                K_STORE, K_STORE_SB: begin
                    if (hit) begin
                        dec.bus   = wt;
                        dec.dirty = !wt;
                    end else if (!(test && kind == K_STORE_SB)) begin
                        dec.alloc = permit;
                        dec.dirty = permit && !wt;
                        dec.bus   = wt || !permit;
                    end
                end
                K_CASTOUT: begin
                    if (hit) begin
                        dec.bus   = wt;
                        dec.dirty = !wt;
                    end else begin
                        dec.alloc = co_take;
                        dec.dirty = co_take && !wt;
                        dec.bus   = wt || !co_take;
                    end
                end
                K_FLUSH_PUSH, K_STORE_PUSH: begin
                    dec.alloc = test && !hit;
                    dec.bus   = !test;
                    dec.inval = !test && hit;
                end
                K_ZERO: begin
                    dec.bcast = !test;
                end
                default: begin
                    dec.bus = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cap_out_stage.sv
// One-entry registered output with valid/ready on both sides.
// Assumes: downstream may hold out_ready low for any number of cycles.
module cap_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    output logic         up_ready,
    input  logic [W-1:0] up_data,
    output logic         dn_valid,
    input  logic         dn_ready,
    output logic [W-1:0] dn_data
);
    // Accept when empty or when the held entry leaves this cycle.
    always_comb up_ready = !dn_valid || dn_ready;

    // Load a new entry or hold the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid) dn_data <= up_data;
        end
    end

endmodule

// File: rtl/cache_alloc_policy.sv
// Top of the allocation policy unit: mode register, decision rules and
// the registered output stage.
// Assumes: one decision in flight; in_id is opaque and returned unchanged.
module cache_alloc_policy
    import cap_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_enable,
    input  logic            cfg_data_only,
    input  logic            cfg_instr_only,
    input  logic            cfg_write_thru,
    input  logic            cfg_test_mode,
    input  logic            cfg_flush_assist,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_src,
    input  logic [2:0]      in_kind,
    input  logic            in_hit,
    input  logic            in_coh,
    input  logic [ID_W-1:0] in_id,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [ID_W-1:0] out_id,
    output logic            out_alloc,
    output logic            out_bus,
    output logic            out_dirty,
    output logic            out_inval,
    output logic            out_bcast
);
    localparam int PAY_W = ID_W + DEC_W;

    logic en_q, wt_q, test_q, fa_q, allow_d, allow_i;
    dec_t dec_now;
    dec_t dec_out;
    logic [PAY_W-1:0] pay_in;
    logic [PAY_W-1:0] pay_out;

    cap_mode_reg u_mode (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_enable       (cfg_enable),
        .cfg_data_only    (cfg_data_only),
        .cfg_instr_only   (cfg_instr_only),
        .cfg_write_thru   (cfg_write_thru),
        .cfg_test_mode    (cfg_test_mode),
        .cfg_flush_assist (cfg_flush_assist),
        .en_q             (en_q),
        .wt_q             (wt_q),
        .test_q           (test_q),
        .fa_q             (fa_q),
        .allow_d          (allow_d),
        .allow_i          (allow_i)
    );

    cap_rules u_rules (
        .en      (en_q),
        .wt      (wt_q),
        .test    (test_q),
        .fa      (fa_q),
        .allow_d (allow_d),
        .allow_i (allow_i),
        .src     (in_src),
        .kind    (kind_e'(in_kind)),
        .hit     (in_hit),
        .coh     (in_coh),
        .dec     (dec_now)
    );

    // Pack tag and decision for the output register.
    always_comb pay_in = {in_id, dec_now};

    cap_out_stage #(.W(PAY_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (pay_in),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (pay_out)
    );

    // Unpack the held decision onto the output ports.
    always_comb begin
        out_id    = pay_out[PAY_W-1:DEC_W];
        dec_out   = pay_out[DEC_W-1:0];
        out_alloc = dec_out.alloc;
        out_bus   = dec_out.bus;
        out_dirty = dec_out.dirty;
        out_inval = dec_out.inval;
        out_bcast = dec_out.bcast;
    end

endmodule

// File: rtl/cache_alloc_policy_chk.sv
// Property checker for cache_alloc_policy; keeps its own record of the
// settings and kind seen at each acceptance.
module cache_alloc_policy_chk #(
    parameter int ID_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_enable,
    input logic            cfg_data_only,
    input logic            cfg_instr_only,
    input logic            cfg_write_thru,
    input logic            cfg_test_mode,
    input logic            in_valid,
    input logic            in_ready,
    input logic [2:0]      in_kind,
    input logic            in_hit,
    input logic            out_valid,
    input logic            out_ready,
    input logic [ID_W-1:0] out_id,
    input logic            out_alloc,
    input logic            out_bus,
    input logic            out_dirty,
    input logic            out_inval,
    input logic            out_bcast
);
    logic p_en, p_wt, p_lock, p_test;
    logic a_en, a_wt, a_lock, a_test, a_hit;
    logic [2:0] a_kind;

    // Settings seen one cycle back, then frozen at each acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_en <= 1'b0; p_wt <= 1'b0; p_lock <= 1'b0; p_test <= 1'b0;
            a_en <= 1'b0; a_wt <= 1'b0; a_lock <= 1'b0; a_test <= 1'b0;
            a_hit <= 1'b0; a_kind <= 3'd0;
        end else begin
            p_en   <= cfg_enable;
            p_wt   <= cfg_write_thru;
            p_lock <= cfg_data_only && cfg_instr_only;
            p_test <= cfg_test_mode;
            if (in_valid && in_ready) begin
                a_en   <= p_en;
                a_wt   <= p_wt;
                a_lock <= p_lock;
                a_test <= p_test;
                a_hit  <= in_hit;
                a_kind <= in_kind;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R1
    AST_OFF_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !a_en |-> out_bus && !out_alloc && !out_dirty && !out_inval); // R2
    AST_LOAD_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && a_en && a_kind == 3'd0 && a_hit |-> !out_bus && !out_alloc); // R4
    AST_LOCK_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && a_en && a_lock && !a_test |-> !out_alloc); // R7
    AST_WT_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && a_en && a_wt |-> !out_dirty); // R8
    AST_TEST_PUSH_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && a_en && a_test && (a_kind == 3'd4 || a_kind == 3'd5)
        |-> !out_bus && !out_inval); // R10
    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R12
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid
        && $stable({out_id, out_alloc, out_bus, out_dirty, out_inval, out_bcast})); // R12

endmodule

bind cache_alloc_policy cache_alloc_policy_chk #(.ID_W(ID_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_data_only  (cfg_data_only),
    .cfg_instr_only (cfg_instr_only),
    .cfg_write_thru (cfg_write_thru),
    .cfg_test_mode  (cfg_test_mode),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .in_kind        (in_kind),
    .in_hit         (in_hit),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_id         (out_id),
    .out_alloc      (out_alloc),
    .out_bus        (out_bus),
    .out_dirty      (out_dirty),
    .out_inval      (out_inval),
    .out_bcast      (out_bcast)
);

// File: tb/cache_alloc_policy_test.sv
module cache_alloc_policy_test;
    localparam int ID_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 0, cfg_data_only = 0, cfg_instr_only = 0;
    logic cfg_write_thru = 0, cfg_test_mode = 0, cfg_flush_assist = 0;
    logic in_valid = 0, in_src = 0, in_hit = 0, in_coh = 0;
    logic [2:0] in_kind = 3'd0;
    logic [ID_W-1:0] in_id = '0;
    logic in_ready, out_valid, out_ready;
    logic [ID_W-1:0] out_id;
    logic out_alloc, out_bus, out_dirty, out_inval, out_bcast;

    always #4 clk = ~clk;

    cache_alloc_policy #(.ID_W(ID_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_data_only(cfg_data_only),
        .cfg_instr_only(cfg_instr_only), .cfg_write_thru(cfg_write_thru),
        .cfg_test_mode(cfg_test_mode), .cfg_flush_assist(cfg_flush_assist),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
        .in_kind(in_kind), .in_hit(in_hit), .in_coh(in_coh), .in_id(in_id),
        .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
        .out_alloc(out_alloc), .out_bus(out_bus), .out_dirty(out_dirty),
        .out_inval(out_inval), .out_bcast(out_bcast)
    );

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic alloc, bus, dirty, inval, bcast;
    } exp_t;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit stall = 0;
    string cur_req = "R4";
    exp_t  exp_q[$];
    string req_q[$];
    logic [5:0] cfg_prev = '0;   // en, do, io, wt, tm, fa

    // Reference decision written from the requirement text.
    function automatic exp_t model(logic [5:0] c, logic src, int k,
                                   logic hit, logic coh, logic [ID_W-1:0] id);
        exp_t r;
        bit en, d_o, i_o, wt, tm, fa, ok, take;
        {en, d_o, i_o, wt, tm, fa} = c;
        r = '0;
        r.id = id;
        if (!en) begin
            r.bus = 1; r.bcast = (k == 6);
            return r;
        end
        if (d_o && i_o) ok = 0;
        else if (d_o) ok = (src == 0);
        else if (i_o) ok = (src == 1);
        else ok = 1;
        if (k == 0) begin
            if (!hit) begin r.bus = 1; r.alloc = ok; end
        end else if (k == 1 || k == 2) begin
            if (hit) begin r.bus = wt; r.dirty = !wt; end
            else if (k == 2 && tm) begin end
            else begin r.alloc = ok; r.dirty = ok && !wt; r.bus = wt || !ok; end
        end else if (k == 3) begin
            take = ok && (coh || fa);
            if (hit) begin r.bus = wt; r.dirty = !wt; end
            else begin r.alloc = take; r.dirty = take && !wt; r.bus = wt || !take; end
        end else if (k == 4 || k == 5) begin
            if (tm) r.alloc = !hit;
            else begin r.bus = 1; r.inval = hit; end
        end else if (k == 6) begin
            r.bcast = !tm;
        end else begin
            r.bus = 1;
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Mid-cycle monitor: latency, payload compare, then record acceptance.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            exp_t got;
            check(out_valid == (exp_q.size() != 0), "R12", "out_valid",
                  int'(out_valid), int'(exp_q.size() != 0));
            if (out_valid && out_ready && exp_q.size() != 0) begin
                exp_t e;
                string rq;
                e  = exp_q.pop_front();
                rq = req_q.pop_front();
                got = '{id: out_id, alloc: out_alloc, bus: out_bus, dirty: out_dirty,
                        inval: out_inval, bcast: out_bcast};
                check(got == e, rq, "decision{id,alloc,bus,dirty,inval,bcast}",
                      int'(got), int'(e));
            end
            if (in_valid && in_ready) begin
                exp_q.push_back(model(cfg_prev, in_src, int'(in_kind), in_hit, in_coh, in_id));
                req_q.push_back(cur_req);
            end
        end
        cfg_prev <= rst_n ? {cfg_enable, cfg_data_only, cfg_instr_only,
                             cfg_write_thru, cfg_test_mode, cfg_flush_assist} : 6'd0;
    end

    // Consumer: always ready, or randomly stalled.
    always @(posedge clk) begin
        #1;
        out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(bit en, bit d_o, bit i_o, bit wt, bit tm, bit fa);
        cfg_enable = en; cfg_data_only = d_o; cfg_instr_only = i_o;
        cfg_write_thru = wt; cfg_test_mode = tm; cfg_flush_assist = fa;
    endtask

    logic [ID_W-1:0] next_id = '0;

    task automatic send(bit src, int k, bit hit, bit coh, string req);
        in_src = src; in_kind = 3'(k); in_hit = hit; in_coh = coh;
        in_id = next_id; next_id = next_id + 1'b1;
        cur_req = req; in_valid = 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 0;
    endtask

    initial begin
        out_ready = 1;
        idle(2);
        @(negedge clk);
        check(out_valid == 0, "R1", "out_valid in reset", int'(out_valid), 0);
        @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        check(in_ready == 1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(out_valid == 0, "R1", "out_valid after reset", int'(out_valid), 0);
        @(posedge clk); #1;

        // R2: disabled, all kinds pass through
        for (int k = 0; k < 8; k++) send(0, k, k[0], 1, "R2");

        // R3: enable presented with the transaction uses old setting
        set_cfg(1, 0, 0, 0, 0, 0);
        send(0, 0, 0, 0, "R3");
        send(0, 0, 0, 0, "R3");
        set_cfg(0, 0, 0, 0, 0, 0);
        send(0, 1, 1, 0, "R3");
        send(0, 1, 1, 0, "R3");
        set_cfg(1, 0, 0, 0, 0, 0); idle(1);

        // R4 loads, R5 write-back stores and castouts
        send(0, 0, 1, 0, "R4"); send(1, 0, 0, 0, "R4"); send(0, 0, 0, 0, "R4");
        send(0, 1, 1, 0, "R5"); send(0, 1, 0, 0, "R5"); send(0, 2, 0, 0, "R5");
        send(0, 3, 1, 0, "R5"); send(0, 2, 1, 0, "R5");

        // R6 data-only then instruction-only
        set_cfg(1, 1, 0, 0, 0, 0); idle(1);
        send(1, 0, 0, 0, "R6"); send(1, 0, 1, 0, "R6"); send(0, 0, 0, 0, "R6");
        send(0, 1, 0, 0, "R6");
        set_cfg(1, 0, 1, 0, 0, 0); idle(1);
        send(0, 0, 0, 0, "R6"); send(0, 0, 1, 0, "R6"); send(1, 0, 0, 0, "R6");
        send(0, 1, 0, 0, "R6");

        // R7 locked; lock change in same cycle as a transaction
        set_cfg(1, 1, 1, 0, 0, 0);
        send(1, 0, 0, 0, "R3");
        for (int k = 0; k < 4; k++) begin
            send(0, k, 0, 1, "R7");
            send(1, k, 0, 1, "R7");
        end

        // R8 write-through
        set_cfg(1, 0, 0, 1, 0, 0); idle(1);
        send(0, 1, 1, 0, "R8"); send(0, 1, 0, 0, "R8"); send(0, 3, 1, 0, "R8");
        send(0, 3, 0, 1, "R8"); send(0, 2, 1, 0, "R8");

        // R9 castout coherence / flush-assist
        for (int fa = 0; fa < 2; fa++) begin
            set_cfg(1, 0, 0, 0, 0, fa[0]); idle(1);
            send(0, 3, 0, 0, "R9"); send(0, 3, 0, 1, "R9");
        end
        set_cfg(1, 0, 1, 0, 0, 1); idle(1);
        send(0, 3, 0, 1, "R9");

        // R10 pushes normal then test mode (including under lock)
        set_cfg(1, 0, 0, 0, 0, 0); idle(1);
        send(0, 4, 1, 0, "R10"); send(0, 5, 0, 0, "R10"); send(0, 5, 1, 0, "R10");
        set_cfg(1, 1, 1, 1, 1, 0); idle(1);
        send(0, 4, 0, 0, "R10"); send(0, 5, 1, 0, "R10"); send(0, 4, 1, 0, "R10");

        // R11 zero broadcast and single-beat misses in test mode
        set_cfg(1, 0, 0, 0, 1, 0); idle(1);
        send(0, 6, 0, 0, "R11"); send(0, 2, 0, 0, "R11"); send(0, 2, 1, 0, "R11");
        send(0, 7, 1, 0, "R11");
        set_cfg(1, 0, 0, 0, 0, 0); idle(1);
        send(0, 6, 1, 0, "R11"); send(0, 7, 0, 0, "R11");

        // R12 random output stall across mixed traffic and modes
        stall = 1;
        for (int i = 0; i < 120; i++) begin
            set_cfg(1, i[2], i[3], i[4], i[5], i[1]);
            send(i[6], (i * 3) % 8, i[0], i[1], "R12");
        end
        stall = 0;
        idle(4);
        finish_run();
    end
endmodule